// File: doc/BRIEF.md
# Amplifier Channel Control and Interrupt Registers

This block is a register slice on a simple APB-style bus. It controls a bank of analog amplifier channels, three by default. For each channel it holds an amplifier enable, an enable for the Schmitt-trigger digital-output buffer, and an interrupt enable, and it drives the first two straight to the analog macro. Each channel's comparator output arrives with no relation to the bus clock. The block brings it through a synchroniser and shows it as status. Every change of that output, rising or falling, is caught in a sticky flag that software clears by writing 1. All channels share one combined interrupt line.

The block also starts calibration for each channel. Software writes a trigger bit that clears itself. The block then sends a one-cycle start pulse to a calibration engine in the same clock domain. When the engine returns a done pulse with NMOS and PMOS pass/fail results, the block records them and clears the trigger. The analog circuits and the calibration algorithm sit outside this block and appear only as ports.

Top module: `amp_chan_regs`

## Requirements
- R1: After reset every register reads 0, and `amp_en`, `buf_en`, `cal_ref_sel`, `cal_start` and `irq` are all 0.
- R2: Word 0x00 holds the amplifier enables at bits [2:0], the buffer enables at [6:4] and the interrupt enables at [10:8]. All other bits read 0. The enables drive `amp_en` and `buf_en` directly. A write to an address whose low two bits are not 0 is ignored.
- R3: Bits [2:0] of word 0x04 show each comparator input after a two-flop synchroniser. A change made between clock edges is visible after the second rising edge and not after the first. Each bit reads 0 while its buffer enable is 0.
- R4: Bits [6:4] of word 0x04 are sticky flags. A flag is set on the rising edge after its synchronised comparator value changes in either direction, but only while that channel's buffer enable is 1. A change that happens while the buffer is disabled sets nothing, even if the buffer is enabled later.
- R5: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a set event and a clear reach the same flag on the same edge, the flag ends up 1.
- R6: `irq` is 1 exactly when at least one flag is 1 and its interrupt enable is also 1.
- R7: Bits [2:0] of word 0x08 are calibration triggers. Writing 1 while that channel's amplifier enable is 1 and its trigger is 0 sets the trigger and makes `cal_start` high for exactly the next cycle. Writing 1 while the amplifier is disabled or the trigger is already set, and writing 0, have no effect.
- R8: Bits [18:16] of word 0x08 read and write freely and drive `cal_ref_sel`, where 0 selects the supply reference and 1 selects the common-mode sweep.
- R9: Word 0x0C is read-only. For channel i it shows done at bit 4i, NMOS fail at bit 4i+1 and PMOS fail at bit 4i+2, where 1 means fail. Starting a calibration clears all three bits of that channel, and writes to the word change nothing.
- R10: A `cal_done_in` pulse while a channel's trigger is set clears the trigger, sets done and captures `cal_nfail_in` and `cal_pfail_in`. A done pulse on a channel whose trigger is clear is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data; 0 when not selected |
| cmp_async | input | NUM_CH | Comparator outputs, asynchronous |
| amp_en | output | NUM_CH | Amplifier enables |
| buf_en | output | NUM_CH | Digital-output buffer enables |
| cal_start | output | NUM_CH | One-cycle calibration start pulses |
| cal_ref_sel | output | NUM_CH | Calibration reference select |
| cal_done_in | input | NUM_CH | Engine done pulses |
| cal_nfail_in | input | NUM_CH | NMOS fail result, valid with done |
| cal_pfail_in | input | NUM_CH | PMOS fail result, valid with done |
| irq | output | 1 | Combined interrupt request |

## Verification
A synchroniser stage that is missing or extra moves the status bit one edge early or late. It also moves the flag, which always follows one edge after the status. The bench samples inside that window, so such a fault appears on the first read after a comparator toggle. A wrong choice between set and clear loses a flag on the edge where the two collide, and `irq` then stays low at once. A calibration tracker in the wrong state shows up within one cycle: the start pulse is missing or repeated, or done and the trigger are both set at the same time.

// File: rtl/amp_regs_pkg.sv
package amp_regs_pkg;
   // word index within the four-word window (byte address bits [3:2])
   localparam int unsigned IDX_CTL    = 0;
   localparam int unsigned IDX_STAT   = 1;
   localparam int unsigned IDX_CALCTL = 2;
   localparam int unsigned IDX_CALST  = 3;

   // field bases inside the words
   localparam int unsigned CTL_AMP_LSB   = 0;
   localparam int unsigned CTL_BUF_LSB   = 4;
   localparam int unsigned CTL_IEN_LSB   = 8;
   localparam int unsigned STAT_DO_LSB   = 0;
   localparam int unsigned STAT_FLG_LSB  = 4;
   localparam int unsigned CAL_TRIG_LSB  = 0;
   localparam int unsigned CAL_REF_LSB   = 16;

   // calibration status: one nibble per channel
   localparam int unsigned CALST_STRIDE  = 4;
   localparam int unsigned CALST_DONE    = 0;
   localparam int unsigned CALST_NFAIL   = 1;
   localparam int unsigned CALST_PFAIL   = 2;

   localparam int unsigned MAX_CH        = 4;
endpackage

// File: rtl/amp_sync_edge.sv
module amp_sync_edge #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] async_in,
   output logic [NUM_CH-1:0] sync_out,
   output logic [NUM_CH-1:0] change
);
   if (STAGES < 2) begin : g_bad_stages
      $error("amp_sync_edge: STAGES must be at least 2");
   end

   logic [NUM_CH-1:0] prev_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], async_in[c]};
      end
      assign sync_out[c] = chain_q[STAGES-1];
   end

   // registered copy for change detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_out;
   end

   assign change = sync_out ^ prev_q;
endmodule

// File: rtl/amp_irq_flags.sv
module amp_irq_flags #(
   parameter int unsigned NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_evt,
   input  logic [NUM_CH-1:0] clr_mask,
   input  logic [NUM_CH-1:0] ien,
   output logic [NUM_CH-1:0] flags,
   output logic              irq
);
   logic [NUM_CH-1:0] flag_q;

   // a set on the same edge as a clear wins
   for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_q[c] <= 1'b0;
         else if (set_evt[c]) flag_q[c] <= 1'b1;
         else if (clr_mask[c]) flag_q[c] <= 1'b0;
      end
   end

   assign flags = flag_q;
   assign irq   = |(flag_q & ien);
endmodule

// File: rtl/amp_cal_chan.sv
module amp_cal_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic amp_on,
   input  logic trig_wr,
   input  logic eng_done,
   input  logic eng_nfail,
   input  logic eng_pfail,
   output logic busy,
   output logic start,
   output logic done,
   output logic nfail,
   output logic pfail
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         start <= 1'b0;
         done  <= 1'b0;
         nfail <= 1'b0;
         pfail <= 1'b0;
      end else begin
         start <= 1'b0;
         if (busy) begin
            if (eng_done) begin
               busy  <= 1'b0;
               done  <= 1'b1;
               nfail <= eng_nfail;
               pfail <= eng_pfail;
            end
         end else if (trig_wr && amp_on) begin
            busy  <= 1'b1;
            start <= 1'b1;
            done  <= 1'b0;
            nfail <= 1'b0;
            pfail <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/amp_chan_regs.sv
module amp_chan_regs
   import amp_regs_pkg::*;
#(
   parameter int unsigned NUM_CH      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AW          = 4,
   parameter int unsigned DW          = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [AW-1:0]     paddr,
   input  logic [DW-1:0]     pwdata,
   output logic [DW-1:0]     prdata,
   input  logic [NUM_CH-1:0] cmp_async,
   output logic [NUM_CH-1:0] amp_en,
   output logic [NUM_CH-1:0] buf_en,
   output logic [NUM_CH-1:0] cal_start,
   output logic [NUM_CH-1:0] cal_ref_sel,
   input  logic [NUM_CH-1:0] cal_done_in,
   input  logic [NUM_CH-1:0] cal_nfail_in,
   input  logic [NUM_CH-1:0] cal_pfail_in,
   output logic              irq
);
   localparam int unsigned TOP_FIELD = CAL_REF_LSB + NUM_CH;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("amp_chan_regs: NUM_CH out of range");
   end
   if (DW < TOP_FIELD) begin : g_bad_dw
      $error("amp_chan_regs: DW too narrow for the field layout");
   end
   if (AW < 4) begin : g_bad_aw
      $error("amp_chan_regs: AW must cover four words");
   end

   // address decode
   logic       addr_ok;
   logic [1:0] word_idx;
   if (AW > 4) begin : g_wide_addr
      assign addr_ok = (paddr[AW-1:4] == '0) && (paddr[1:0] == 2'b00);
   end else begin : g_narrow_addr
      assign addr_ok = (paddr[1:0] == 2'b00);
   end
   assign word_idx = paddr[3:2];

   logic wr_stb, wr_ctl, wr_stat, wr_calctl;
   assign wr_stb    = psel && penable && pwrite && addr_ok;
   assign wr_ctl    = wr_stb && (word_idx == 2'(IDX_CTL));
   assign wr_stat   = wr_stb && (word_idx == 2'(IDX_STAT));
   assign wr_calctl = wr_stb && (word_idx == 2'(IDX_CALCTL));

   // control and reference registers
   logic [NUM_CH-1:0] amp_en_q, buf_en_q, ien_q, ref_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         amp_en_q <= '0;
         buf_en_q <= '0;
         ien_q    <= '0;
      end else if (wr_ctl) begin
         amp_en_q <= pwdata[CTL_AMP_LSB +: NUM_CH];
         buf_en_q <= pwdata[CTL_BUF_LSB +: NUM_CH];
         ien_q    <= pwdata[CTL_IEN_LSB +: NUM_CH];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ref_q <= '0;
      else if (wr_calctl) ref_q <= pwdata[CAL_REF_LSB +: NUM_CH];
   end

   // comparator path
   logic [NUM_CH-1:0] sync_do, do_change, status_do;
   amp_sync_edge #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (cmp_async),
      .sync_out (sync_do),
      .change   (do_change)
   );
   assign status_do = sync_do & buf_en_q;

   logic [NUM_CH-1:0] flag_q, clr_eff, set_evt;
   assign clr_eff = wr_stat ? pwdata[STAT_FLG_LSB +: NUM_CH] : '0;
   assign set_evt = do_change & buf_en_q;

   amp_irq_flags #(.NUM_CH(NUM_CH)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_evt  (set_evt),
      .clr_mask (clr_eff),
      .ien      (ien_q),
      .flags    (flag_q),
      .irq      (irq)
   );

   // calibration trackers
   logic [NUM_CH-1:0] cal_trig, cal_done_st, cal_nf, cal_pf;
   for (genvar c = 0; c < NUM_CH; c++) begin : g_cal
      amp_cal_chan u_cal (
         .clk       (clk),
         .rst_n     (rst_n),
         .amp_on    (amp_en_q[c]),
         .trig_wr   (wr_calctl && pwdata[CAL_TRIG_LSB + c]),
         .eng_done  (cal_done_in[c]),
         .eng_nfail (cal_nfail_in[c]),
         .eng_pfail (cal_pfail_in[c]),
         .busy      (cal_trig[c]),
         .start     (cal_start[c]),
         .done      (cal_done_st[c]),
         .nfail     (cal_nf[c]),
         .pfail     (cal_pf[c])
      );
   end

   // read mux
   logic [DW-1:0] rdata;
   always_comb begin
      rdata = '0;
      unique case (word_idx)
         2'(IDX_CTL): begin
            rdata[CTL_AMP_LSB +: NUM_CH] = amp_en_q;
            rdata[CTL_BUF_LSB +: NUM_CH] = buf_en_q;
            rdata[CTL_IEN_LSB +: NUM_CH] = ien_q;
         end
         2'(IDX_STAT): begin
            rdata[STAT_DO_LSB  +: NUM_CH] = status_do;
            rdata[STAT_FLG_LSB +: NUM_CH] = flag_q;
         end
         2'(IDX_CALCTL): begin
            rdata[CAL_TRIG_LSB +: NUM_CH] = cal_trig;
            rdata[CAL_REF_LSB  +: NUM_CH] = ref_q;
         end
         default: begin
            for (int c = 0; c < NUM_CH; c++) begin
               rdata[CALST_STRIDE*c + CALST_DONE]  = cal_done_st[c];
               rdata[CALST_STRIDE*c + CALST_NFAIL] = cal_nf[c];
               rdata[CALST_STRIDE*c + CALST_PFAIL] = cal_pf[c];
            end
         end
      endcase
   end

   assign prdata      = (psel && addr_ok) ? rdata : '0;
   assign amp_en      = amp_en_q;
   assign buf_en      = buf_en_q;
   assign cal_ref_sel = ref_q;

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^pwdata;
endmodule

// File: rtl/amp_chan_regs_chk.sv
module amp_chan_regs_chk #(
   parameter int unsigned NUM_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic [NUM_CH-1:0] ien,
   input logic [NUM_CH-1:0] flags,
   input logic [NUM_CH-1:0] w1c_mask,
   input logic [NUM_CH-1:0] amp_en,
   input logic [NUM_CH-1:0] cal_start,
   input logic [NUM_CH-1:0] cal_trig,
   input logic [NUM_CH-1:0] cal_done,
   input logic [NUM_CH-1:0] cal_done_in
);
   // R5: a flag only falls on an edge where a write-1 hit it
   a_r5_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(flags) & ~$past(w1c_mask) & ~flags) == '0));

   // R6: no enable, no request
   a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);

   // R7: start only for an enabled amplifier
   a_r7_start_needs_amp: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_start & ~amp_en) == '0);

   // R7: start lasts one cycle
   a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_start != '0) |=> ((cal_start & $past(cal_start)) == '0));

   // R9: a running calibration never shows done
   a_r9_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_trig & cal_done) == '0);

   // R10: engine done ends the run
   a_r10_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((cal_trig & cal_done_in) != '0) |=>
         ((cal_trig & $past(cal_trig & cal_done_in)) == '0));
endmodule

bind amp_chan_regs amp_chan_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq         (irq),
   .ien         (ien_q),
   .flags       (flag_q),
   .w1c_mask    (clr_eff),
   .amp_en      (amp_en_q),
   .cal_start   (cal_start),
   .cal_trig    (cal_trig),
   .cal_done    (cal_done_st),
   .cal_done_in (cal_done_in)
);

// File: tb/amp_chan_regs_test.sv
module amp_chan_regs_test;
   localparam int unsigned N = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [3:0]    paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   prdata;
   logic [N-1:0]  cmp_async = '0;
   logic [N-1:0]  amp_en, buf_en, cal_start, cal_ref_sel;
   logic [N-1:0]  cal_done_in = '0, cal_nfail_in = '0, cal_pfail_in = '0;
   logic          irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   amp_chan_regs uut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cmp_async(cmp_async),
      .amp_en(amp_en), .buf_en(buf_en), .cal_start(cal_start),
      .cal_ref_sel(cal_ref_sel), .cal_done_in(cal_done_in),
      .cal_nfail_in(cal_nfail_in), .cal_pfail_in(cal_pfail_in), .irq(irq)
   );

   localparam logic [3:0] A_CTL = 4'h0, A_STAT = 4'h4, A_CAL = 4'h8, A_CALST = 4'hC;

   typedef struct packed {
      logic [3:0]  addr;
      logic [31:0] wdata;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [0:NV-1] = '{
      '{A_CTL,   32'hFFFF_FFFF, 32'h0000_0777},  // R2 only mapped fields
      '{A_CTL,   32'h0000_0155, 32'h0000_0155},  // R2 mixed pattern
      '{A_CTL,   32'h0000_0000, 32'h0000_0000},  // R2 clear
      '{A_CAL,   32'hFFFF_FFFF, 32'h0007_0000},  // R7 triggers ignored with amps off, R8 ref bits
      '{A_CAL,   32'h0000_0000, 32'h0000_0000},  // R8 clear
      '{A_CALST, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 read-only
      '{A_STAT,  32'hFFFF_FFFF, 32'h0000_0000}   // R3 buffers off, R5 nothing to clear
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
      end
   endtask

   // all bus tasks start and end just after a falling edge
   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(posedge clk); @(negedge clk);
      penable = 1'b1;
      @(posedge clk); @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(posedge clk); @(negedge clk);
      penable = 1'b1;
      #1 d = prdata;
      @(posedge clk); @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic read_check(input string req, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(req, d, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      read_check("R1 ctl",    A_CTL,   32'h0);
      read_check("R1 status", A_STAT,  32'h0);
      read_check("R1 calctl", A_CAL,   32'h0);
      read_check("R1 calst",  A_CALST, 32'h0);
      check("R1 outputs", {27'd0, irq, amp_en, buf_en, cal_ref_sel, cal_start}, 32'h0);

      // table of register vectors
      for (int i = 0; i < NV; i++) begin
         logic [31:0] d;
         bus_write(VECS[i].addr, VECS[i].wdata);
         bus_read(VECS[i].addr, d);
         check($sformatf("vector %0d", i), d, VECS[i].exp);
      end

      // R2 port drive; misaligned write ignored
      bus_write(A_CTL, 32'h155);
      check("R2 amp_en", {29'd0, amp_en}, 32'h5);
      check("R2 buf_en", {29'd0, buf_en}, 32'h5);
      bus_write(4'h1, 32'h0);
      read_check("R2 misaligned ignored", A_CTL, 32'h155);
      bus_write(A_CTL, 32'h0);

      // R8 reference select drive
      bus_write(A_CAL, 32'h0005_0000);
      check("R8 cal_ref_sel", {29'd0, cal_ref_sel}, 32'h5);
      bus_write(A_CAL, 32'h0);

      // R3/R4 synchroniser latency and flag set, channel 0
      bus_write(A_CTL, 32'h010);
      cmp_async[0] = 1'b1;
      idle(1);
      read_check("R3 status after two edges", A_STAT, 32'h01);
      read_check("R4 flag on rise", A_STAT, 32'h11);
      check("R6 irq off without enable", {31'd0, irq}, 32'h0);
      bus_write(A_CTL, 32'h110);
      check("R6 irq with enable", {31'd0, irq}, 32'h1);
      bus_write(A_STAT, 32'h10);
      check("R5 irq drops after clear", {31'd0, irq}, 32'h0);

      // R3 one edge is not enough; R4 falling change
      cmp_async[0] = 1'b0;
      read_check("R3 not yet after one edge", A_STAT, 32'h01);
      read_check("R4 flag on fall", A_STAT, 32'h10);
      check("R6 irq on fall", {31'd0, irq}, 32'h1);
      bus_write(A_STAT, 32'h0);
      read_check("R5 write 0 keeps flag", A_STAT, 32'h10);
      bus_write(A_STAT, 32'h10);
      read_check("R5 write 1 clears", A_STAT, 32'h00);

      // R5 set wins over same-edge clear
      cmp_async[0] = 1'b1;
      idle(1);
      bus_write(A_STAT, 32'h10);
      read_check("R5 set wins", A_STAT, 32'h11);
      bus_write(A_STAT, 32'h10);
      read_check("R5 cleared after", A_STAT, 32'h01);

      // R3/R4 buffer gating on channel 1
      cmp_async[1] = 1'b1;
      idle(4);
      read_check("R3 gated while buffer off", A_STAT, 32'h01);
      bus_write(A_CTL, 32'h130);
      read_check("R4 no flag from change while off", A_STAT, 32'h03);
      cmp_async[1] = 1'b0;
      idle(4);
      read_check("R4 channel 1 fall", A_STAT, 32'h21);
      check("R6 no irq for channel 1", {31'd0, irq}, 32'h0);
      bus_write(A_CTL, 32'h330);
      check("R6 irq channel 1", {31'd0, irq}, 32'h1);
      bus_write(A_STAT, 32'h20);
      check("R6 irq cleared", {31'd0, irq}, 32'h0);

      // R7 calibration triggers
      bus_write(A_CTL, 32'h000);
      bus_write(A_CAL, 32'h1);
      check("R7 no start with amp off", {29'd0, cal_start}, 32'h0);
      read_check("R7 trigger ignored with amp off", A_CAL, 32'h0);
      bus_write(A_CTL, 32'h003);
      bus_write(A_CAL, 32'h1);
      check("R7 start pulse", {29'd0, cal_start}, 32'h1);
      idle(1);
      check("R7 start one cycle", {29'd0, cal_start}, 32'h0);
      read_check("R7 trigger set", A_CAL, 32'h1);
      read_check("R9 done low while busy", A_CALST, 32'h0);
      bus_write(A_CAL, 32'h1);
      check("R7 no second start", {29'd0, cal_start}, 32'h0);
      bus_write(A_CAL, 32'h0);
      read_check("R7 write 0 no effect", A_CAL, 32'h1);

      // R10 engine done with NMOS fail on channel 0
      cal_nfail_in = 3'b001; cal_done_in = 3'b001;
      idle(1);
      cal_nfail_in = '0; cal_done_in = '0;
      read_check("R10 done and nmos fail", A_CALST, 32'h003);
      read_check("R10 trigger cleared", A_CAL, 32'h0);

      // channel 1 with PMOS fail
      bus_write(A_CAL, 32'h2);
      check("R7 start channel 1", {29'd0, cal_start}, 32'h2);
      cal_pfail_in = 3'b010; cal_done_in = 3'b010;
      idle(1);
      cal_pfail_in = '0; cal_done_in = '0;
      read_check("R9 channel 1 field position", A_CALST, 32'h053);

      // R10 done on idle channel ignored
      cal_nfail_in = 3'b100; cal_done_in = 3'b100;
      idle(1);
      cal_nfail_in = '0; cal_done_in = '0;
      read_check("R10 idle done ignored", A_CALST, 32'h053);

      // R9 restart clears channel 0 status; writes ignored
      bus_write(A_CAL, 32'h1);
      read_check("R9 restart clears status", A_CALST, 32'h050);
      bus_write(A_CALST, 32'hFFF);
      read_check("R9 read-only", A_CALST, 32'h050);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule